// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an external 8192-word by 8-bit asynchronous static RAM. The host hands over one word transfer at a time through a request/ready handshake. The block then turns it into a fixed sequence on the memory pins: select the RAM, pulse write enable or output enable for long enough, and release the select. The data word is returned to the host with a single-cycle valid strobe.

The RAM is selected only when its active-low select is low and its active-high select is high at the same time. The block drives both selects together and keeps the RAM in standby whenever it is idle. The lengths of the strobes come from nanosecond parameters and the clock period, each rounded up to whole cycles. Write data leaves the block on a separate output with its own driver enable, so a pad ring can form the shared bidirectional bus. Output enable stays high for the whole of every write, and the block's driver is off for the whole of every read. The two sides can therefore never drive the bus at the same time.

Top module: `sram_seq_ctrl`

## Requirements
- R1: A request is accepted on a rising edge where host_req and host_ready are both high. host_ready is low from the cycle after acceptance until the transfer ends, which takes N+2 cycles for a strobe of N cycles. It is high again in the cycle after that.
- R2: While idle and while in reset, the pins rest in standby: mem_cs1_n=1, mem_cs2=0, mem_we_n=1, mem_oe_n=1 and mem_dq_oe=0, and host_rvalid=0.
- R3: During a transfer, the pins hold the address and write data latched at acceptance. Host input changes while host_ready is low have no effect on them.
- R4: A write drives mem_we_n low for exactly WR cycles, with mem_oe_n high throughout. mem_dq_oe is high and mem_dq_out equals the write data from the fall of mem_we_n to one cycle after its rise.
- R5: A read drives mem_oe_n low for exactly RD cycles, with mem_we_n high and mem_dq_oe low throughout.
- R6: Read data is sampled from mem_dq_in on the last cycle of the output-enable strobe. It is shown on host_rdata with host_rvalid high for exactly one cycle, the cycle right after the strobe. host_rvalid never rises for a write.
- R7: Both selects go active one cycle before the strobe begins and stay active for one cycle after it ends. During those two cycles mem_we_n and mem_oe_n are both high.
- R8: mem_dq_oe is never high while mem_oe_n is low, and mem_we_n and mem_oe_n are never low together.
- R9: RD = ceil(T_AA_NS/CLK_NS) and WR = max(ceil(T_WP_NS/CLK_NS), ceil(T_DW_NS/CLK_NS)), each at least 1.
- R10: A word written to any address is read back unchanged, including addresses 0 and 8191 and the data values 0x00 and 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Transfer request |
| host_ready | output | 1 | High when a request can be accepted |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 13 | Word address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data |
| host_rvalid | output | 1 | One-cycle read-data strobe |
| mem_addr | output | 13 | RAM address pins |
| mem_cs1_n | output | 1 | Active-low RAM select |
| mem_cs2 | output | 1 | Active-high RAM select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data toward the RAM |
| mem_dq_in | input | 8 | Data from the RAM |
| mem_dq_oe | output | 1 | Driver enable for mem_dq_out |

## Verification
The bench builds the block with CLK_NS=20, T_AA_NS=50, T_WP_NS=35 and T_DW_NS=10. This gives a 3-cycle read strobe and a 2-cycle write pulse, so the down-counter runs past one cycle and the data-setup term is outweighed by the pulse term. With these values every one of the 8192 addresses is written and then read back, and each transfer's pin phases are checked cycle by cycle. A behavioural RAM on the bench returns wrong data until the access time has elapsed. It also measures each write pulse and data setup in nanoseconds.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_RECOVER
    } phase_e;

    typedef struct packed {
        logic cs1_n;
        logic cs2;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_STANDBY = '{cs1_n: 1'b1, cs2: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

    function automatic int unsigned cycles_ceil(input int unsigned ns, input int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic pin_ctl_t pins_for(input phase_e ph, input logic is_wr);
        pin_ctl_t p;
        p = PINS_STANDBY;
        unique case (ph)
            PH_IDLE: p = PINS_STANDBY;
            PH_SETUP: begin
                p.cs1_n = 1'b0;
                p.cs2   = 1'b1;
            end
            PH_STROBE: begin
                p.cs1_n = 1'b0;
                p.cs2   = 1'b1;
                p.we_n  = ~is_wr;
                p.oe_n  = is_wr;
                p.dq_oe = is_wr;
            end
            PH_RECOVER: begin
                p.cs1_n = 1'b0;
                p.cs2   = 1'b1;
                p.dq_oe = is_wr;
            end
            default: p = PINS_STANDBY;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_seq_timer.sv
`timescale 1ns/1ps
module sram_seq_timer
    import sram_seq_pkg::*;
#(
    parameter int unsigned RD_CYC = 1,
    parameter int unsigned WR_CYC = 1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   is_wr,
    output phase_e phase_q,
    output phase_e phase_nxt,
    output logic   last_strobe
);
    localparam int unsigned MAXC = max_u(RD_CYC, WR_CYC);
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] RD_LOAD = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] WR_LOAD = CW'(WR_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign last_strobe = (phase_q == PH_STROBE) && (cnt_q == '0);

    always_comb begin
        phase_nxt = phase_q;
        unique case (phase_q)
            PH_IDLE:    if (start) phase_nxt = PH_SETUP;
            PH_SETUP:   phase_nxt = PH_STROBE;
            PH_STROBE:  if (cnt_q == '0) phase_nxt = PH_RECOVER;
            PH_RECOVER: phase_nxt = PH_IDLE;
            default:    phase_nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_nxt;
            if (phase_q == PH_SETUP)
                cnt_q <= is_wr ? WR_LOAD : RD_LOAD;
            else if (phase_q == PH_STROBE && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/sram_seq_pins.sv
`timescale 1ns/1ps
module sram_seq_pins
    import sram_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  phase_e   phase_nxt,
    input  logic     is_wr,
    output pin_ctl_t pins_q
);
    always_ff @(posedge clk) begin
        if (rst) pins_q <= PINS_STANDBY;
        else     pins_q <= pins_for(phase_nxt, is_wr);
    end
endmodule

// File: rtl/sram_seq_datapath.sv
`timescale 1ns/1ps
module sram_seq_datapath #(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              in_wr,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output logic              wr_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rvalid_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q     <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            if (accept) begin
                wr_q    <= in_wr;
                addr_q  <= in_addr;
                wdata_q <= in_wdata;
            end
            rvalid_q <= capture && !wr_q;
            if (capture && !wr_q) rdata_q <= bus_in;
        end
    end
endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int unsigned ADDR_W  = 13,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned CLK_NS  = 20,
    parameter int unsigned T_AA_NS = 20,
    parameter int unsigned T_WP_NS = 15,
    parameter int unsigned T_DW_NS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    output logic              host_ready,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int unsigned RD_CYC = cycles_ceil(T_AA_NS, CLK_NS);
    localparam int unsigned WR_CYC = max_u(cycles_ceil(T_WP_NS, CLK_NS),
                                           cycles_ceil(T_DW_NS, CLK_NS));

    phase_e   phase_q;
    phase_e   phase_nxt;
    logic     last_strobe;
    logic     accept;
    logic     wr_q;
    pin_ctl_t pins_q;

    assign host_ready = (phase_q == PH_IDLE);
    assign accept     = host_req && host_ready;

    sram_seq_timer #(
        .RD_CYC (RD_CYC),
        .WR_CYC (WR_CYC)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .is_wr       (wr_q),
        .phase_q     (phase_q),
        .phase_nxt   (phase_nxt),
        .last_strobe (last_strobe)
    );

    sram_seq_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .in_wr    (host_wr),
        .in_addr  (host_addr),
        .in_wdata (host_wdata),
        .capture  (last_strobe),
        .bus_in   (mem_dq_in),
        .wr_q     (wr_q),
        .addr_q   (mem_addr),
        .wdata_q  (mem_dq_out),
        .rdata_q  (host_rdata),
        .rvalid_q (host_rvalid)
    );

    sram_seq_pins u_pins (
        .clk       (clk),
        .rst       (rst),
        .phase_nxt (phase_nxt),
        .is_wr     (wr_q),
        .pins_q    (pins_q)
    );

    assign mem_cs1_n = pins_q.cs1_n;
    assign mem_cs2   = pins_q.cs2;
    assign mem_we_n  = pins_q.we_n;
    assign mem_oe_n  = pins_q.oe_n;
    assign mem_dq_oe = pins_q.dq_oe;
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
`timescale 1ns/1ps
module sram_seq_ctrl_chk #(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned WR_CYC = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              host_req,
    input logic              host_ready,
    input logic              host_rvalid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs1_n,
    input logic              mem_cs2,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);
    logic [31:0] we_lo_cnt;

    always_ff @(posedge clk) begin
        if (rst)            we_lo_cnt <= '0;
        else if (!mem_we_n) we_lo_cnt <= we_lo_cnt + 1;
        else                we_lo_cnt <= '0;
    end

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_ready) |=> !host_ready);                                   // R1
    AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (rst)
        host_ready |-> (mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe)); // R2
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr));                   // R3
    AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_lo_cnt == WR_CYC));                                  // R4
    AST_WE_WITH_DRIVER: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_dq_oe);                                                    // R4
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |=> !host_rvalid);                                               // R6
    AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n || !mem_oe_n) |-> (!mem_cs1_n && mem_cs2));                       // R7
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        !(mem_dq_oe && !mem_oe_n));                                                  // R8
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(!mem_we_n && !mem_oe_n));                                                  // R8
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .WR_CYC (WR_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_req    (host_req),
    .host_ready  (host_ready),
    .host_rvalid (host_rvalid),
    .mem_addr    (mem_addr),
    .mem_cs1_n   (mem_cs1_n),
    .mem_cs2     (mem_cs2),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_dq_oe   (mem_dq_oe)
);

// File: tb/sram_seq_ctrl_test.sv
`timescale 1ns/1ps
module sram_seq_ctrl_test;
    localparam int TB_CLK = 20;
    localparam int TB_AA  = 50;
    localparam int TB_WP  = 35;
    localparam int TB_DW  = 10;
    localparam int RD_EXP = (TB_AA + TB_CLK - 1) / TB_CLK;
    localparam int WP_C   = (TB_WP + TB_CLK - 1) / TB_CLK;
    localparam int DW_C   = (TB_DW + TB_CLK - 1) / TB_CLK;
    localparam int WR_EXP = (WP_C > DW_C) ? WP_C : DW_C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [12:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ready, host_rvalid;
    logic [7:0]  host_rdata;
    logic [12:0] mem_addr;
    logic        mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out, mem_dq_in;

    int n_chk = 0;
    int n_fail = 0;
    int we_chk = 0;
    int we_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sram_seq_ctrl #(
        .ADDR_W(13), .DATA_W(8), .CLK_NS(TB_CLK),
        .T_AA_NS(TB_AA), .T_WP_NS(TB_WP), .T_DW_NS(TB_DW)
    ) uut (
        .clk(clk), .rst(rst), .host_req(host_req), .host_ready(host_ready),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .mem_addr(mem_addr),
        .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe)
    );

    // Behavioural RAM with timing monitors
    logic [7:0] ram [0:8191];
    logic       data_ok = 1'b0;
    realtime    t_chg = 0.0;
    realtime    t_data = 0.0;
    realtime    t_we_fall = 0.0;
    wire        sel = !mem_cs1_n && mem_cs2;
    wire        ram_drive = sel && mem_we_n && !mem_oe_n;
    wire [7:0]  ram_q = data_ok ? ram[mem_addr] : ~ram[mem_addr];

    assign mem_dq_in = mem_dq_oe ? mem_dq_out : (ram_drive ? ram_q : 8'h00);

    always @(mem_addr or mem_cs1_n or mem_cs2) t_chg = $realtime;
    always @(mem_dq_oe or mem_dq_out) t_data = $realtime;
    always @(negedge mem_we_n) t_we_fall = $realtime;
    always @(negedge clk) data_ok <= (($realtime - t_chg) >= TB_AA);

    always @(posedge mem_we_n) begin
        if (!rst) begin
            we_chk = we_chk + 3;
            if (($realtime - t_we_fall) < TB_WP) begin
                we_bad++;
                $display("FAIL R4 WE pulse width actual=%0f ns expected>=%0d ns", $realtime - t_we_fall, TB_WP);
            end
            if (($realtime - t_data) < TB_DW || !mem_dq_oe) begin
                we_bad++;
                $display("FAIL R4 data setup actual=%0f ns oe=%0b expected>=%0d ns oe=1", $realtime - t_data, mem_dq_oe, TB_DW);
            end
            if (!sel) begin
                we_bad++;
                $display("FAIL R7 write without select actual=0 expected=1");
            end
            ram[mem_addr] <= mem_dq_out;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wrap_up(input int extra);
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk + we_chk + extra, n_fail + we_bad + extra);
        $finish;
    endtask

    function automatic logic [7:0] pat(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b000} ^ 8'h5A;
    endfunction

    task automatic do_op(input bit wr, input logic [12:0] a, input logic [7:0] d);
        int busy;
        int strobes;
        int exp_n;
        exp_n = wr ? WR_EXP : RD_EXP;
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
        while (!host_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        host_req = 1'b0; host_wr = ~wr; host_addr = ~a; host_wdata = ~d;
        busy = 0;
        strobes = 0;
        while (!host_ready && busy < 50) begin
            chk(mem_addr == a, "R3 address held", int'(mem_addr), int'(a));
            chk(!mem_cs1_n && mem_cs2, "R7 selects active", {mem_cs1_n, mem_cs2}, 1);
            chk(!(mem_dq_oe && ram_drive), "R8 bus contention", 1, 0);
            if (wr ? !mem_we_n : !mem_oe_n) strobes++;
            if (busy == 0) begin
                chk(mem_we_n && mem_oe_n && !mem_dq_oe, "R7 setup cycle strobes",
                    {mem_we_n, mem_oe_n, mem_dq_oe}, 3'b110);
            end else if (busy <= exp_n) begin
                if (wr) begin
                    chk(!mem_we_n && mem_oe_n && mem_dq_oe, "R4 write strobe pins",
                        {mem_we_n, mem_oe_n, mem_dq_oe}, 3'b011);
                    chk(mem_dq_out == d, "R3 write data held", int'(mem_dq_out), int'(d));
                end else begin
                    chk(mem_we_n && !mem_oe_n && !mem_dq_oe, "R5 read strobe pins",
                        {mem_we_n, mem_oe_n, mem_dq_oe}, 3'b100);
                end
            end else begin
                chk(mem_we_n && mem_oe_n && (mem_dq_oe == wr), "R7 recovery pins",
                    {mem_we_n, mem_oe_n, mem_dq_oe}, {2'b11, wr});
                if (wr) chk(mem_dq_out == d, "R4 data held after WE", int'(mem_dq_out), int'(d));
            end
            chk(host_rvalid == (!wr && busy == exp_n + 1), "R6 valid strobe timing",
                host_rvalid, (!wr && busy == exp_n + 1));
            if (!wr && busy == exp_n + 1)
                chk(host_rdata == d, "R10 read data", int'(host_rdata), int'(d));
            busy++;
            @(negedge clk);
        end
        chk(busy == exp_n + 2, "R1 busy length", busy, exp_n + 2);
        chk(strobes == exp_n, "R9 strobe cycles", strobes, exp_n);
        chk(mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe && !host_rvalid,
            "R2 standby after transfer",
            {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe, host_rvalid}, 6'b101100);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            wrap_up(1);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe,
            "R2 reset pins", {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
        chk(host_ready && !host_rvalid, "R2 reset handshake", {host_ready, host_rvalid}, 2'b10);
        rst = 1'b0;
        @(negedge clk);
        chk(host_ready, "R1 ready after reset", host_ready, 1);

        // Full sweep: write every address, then read every address back
        for (int a = 0; a < 8192; a++) do_op(1'b1, 13'(a), pat(13'(a)));
        for (int a = 0; a < 8192; a++) do_op(1'b0, 13'(a), pat(13'(a)));

        // Boundary addresses and data values, back-to-back write/read
        do_op(1'b1, 13'd0, 8'h00);
        do_op(1'b1, 13'd8191, 8'hFF);
        do_op(1'b0, 13'd0, 8'h00);
        do_op(1'b0, 13'd8191, 8'hFF);
        do_op(1'b1, 13'd8191, 8'h00);
        do_op(1'b0, 13'd8191, 8'h00);
        do_op(1'b1, 13'd0, 8'hFF);
        do_op(1'b0, 13'd0, 8'hFF);
        do_op(1'b0, 13'd4096, pat(13'd4096));

        // Idle: request low keeps the RAM in standby
        repeat (4) begin
            @(negedge clk);
            chk(host_ready && mem_cs1_n && !mem_cs2 && !mem_dq_oe, "R2 idle standby",
                {host_ready, mem_cs1_n, mem_cs2, mem_dq_oe}, 4'b1100);
        end
        done = 1'b1;
        wrap_up(0);
    end
endmodule